// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block derives the three clocks of an audio serial link from one peripheral clock. A master clock divides the input by a programmable whole ratio, and one setting passes the input straight through. A bit clock divides the input by an even ratio. A word-select clock is built by counting bit-clock periods, so each level lasts a programmable number of bit clocks. Two strobes, each one input cycle wide, mark the rising and the falling edges of the bit clock. A serialiser in the same clock domain can use them as clock enables.

Software sets three code fields and raises the enable. While the enable is low, every output is low and every counter is idle. A changed code takes effect only when the counter that uses it reloads, so a running clock never shows a cut-short phase. The word-select code has seventeen legal values. Larger codes are treated as the longest legal setting.

Top module: `audio_clkgen`

## Requirements
- R1: For a master code c from 1 to 63, the master clock repeats every c+1 input cycles. It is high for c/2+1 cycles (integer division) and low for the rest, so an odd ratio has the longer high phase.
- R2: With master code 0 and the block enabled, the master clock follows the input clock: high while the input clock is high and low while it is low.
- R3: For a bit code b from 0 to 255, each high phase and each low phase of the bit clock lasts exactly b+1 input cycles.
- R4: The rise strobe is high for exactly the first input cycle of each bit-clock high phase. The fall strobe is high for exactly the first input cycle of each bit-clock low phase. The two are never high together.
- R5: For a word-select code w from 0 to 16, each word-select level lasts 16+w bit-clock periods, counted as falling edges of the bit clock.
- R6: A word-select code from 17 to 31 gives 32 bit-clock periods per level.
- R7: After the enable rises, the word-select clock starts low. It changes only in the input cycle in which the bit clock falls, which is the cycle in which the fall strobe is high.
- R8: Within three input cycles of the enable going low, all five outputs are low and stay low.
- R9: All outputs are low during reset. With all three codes at 0 the block runs at master 1/1, bit 1/2 and 16 bit clocks per word-select level.
- R10: A code change while enabled never produces a phase whose length matches neither the old code nor the new one. Each phase runs entirely on one setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock, source of all three clocks |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Run enable; low holds every output low |
| mclk_code_i | input | 6 | Master-clock code, ratio code+1 |
| bclk_code_i | input | 8 | Bit-clock code, half period code+1 input cycles |
| ws_code_i | input | 5 | Word-select code, level length 16+code bit clocks, clamped at 16 |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word-select clock |
| bclk_rise_o | output | 1 | One-cycle strobe at each bit-clock rising edge |
| bclk_fall_o | output | 1 | One-cycle strobe at each bit-clock falling edge |

## Verification
The hardest case to reach is a code change that lands in the middle of a running phase. It has to be shown that the divider finishes that phase on the old value and starts the next one on the new value. The stimulus changes all three codes while the block runs. For a window after the change, the monitor accepts a phase length only if it matches the old code or the new one, and then it narrows to the new one. Reserved word-select codes and the slowest bit-clock code are also driven directly, because random draws rarely reach them within a short run.

// File: rtl/acg_pkg.sv
package acg_pkg;
  localparam int unsigned ACG_MDIV_W      = 6;
  localparam int unsigned ACG_BDIV_W      = 8;
  localparam int unsigned ACG_WS_W        = 5;
  localparam int unsigned ACG_WS_BASE     = 16;
  localparam int unsigned ACG_WS_MAX_CODE = 16;
  localparam int unsigned ACG_SYNC_STAGES = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } acg_edge_t;
endpackage

// File: rtl/acg_mclk_div.sv
module acg_mclk_div #(
  parameter int unsigned DIV_W = acg_pkg::ACG_MDIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] code_i,
  output logic             mclk_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] ratio_q, ratio_d;
  logic             phase_q, phase_d;
  logic             pass_q, pass_d;

  // Down counter; an idle counter sits at zero so the first run cycle reloads.
  always_comb begin
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    if (!run_i) begin
      cnt_d   = '0;
      ratio_d = code_i;
    end else if (cnt_q == '0) begin
      cnt_d   = code_i;
      ratio_d = code_i;
    end else begin
      cnt_d   = cnt_q - 1'b1;
    end
    phase_d = run_i && (cnt_d >= (ratio_d - (ratio_d >> 1)));
    pass_d  = run_i && (ratio_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      phase_q <= phase_d;
    end
  end

  // Select updated while the input clock is low, so the gated path is clean.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pass_q <= 1'b0;
    else         pass_q <= pass_d;
  end

  assign mclk_o = pass_q ? clk_i : phase_q;

  AST_MCLK_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= ratio_q)); // R1
  AST_MCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !phase_q); // R8
endmodule

// File: rtl/acg_bclk_div.sv
module acg_bclk_div #(
  parameter int unsigned DIV_W = acg_pkg::ACG_BDIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] code_i,
  output logic             bclk_o,
  output logic             fall_next_o,
  output acg_pkg::acg_edge_t edge_o
);
  logic [DIV_W-1:0]   cnt_q, cnt_d;
  logic               bclk_q, bclk_d;
  logic               wrap;
  acg_pkg::acg_edge_t edge_q, edge_d;

  always_comb begin
    wrap        = run_i && (cnt_q == '0);
    cnt_d       = cnt_q;
    bclk_d      = bclk_q;
    if (!run_i) begin
      cnt_d  = '0;
      bclk_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = code_i;
      bclk_d = ~bclk_q;
    end else begin
      cnt_d  = cnt_q - 1'b1;
    end
    fall_next_o = wrap && bclk_q;
    edge_d.rise = wrap && !bclk_q;
    edge_d.fall = fall_next_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
      edge_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
      edge_q <= edge_d;
    end
  end

  assign bclk_o = bclk_q;
  assign edge_o = edge_q;

  AST_BCLK_RISE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_q.rise |-> (bclk_q && !$past(bclk_q))); // R4
  AST_BCLK_FALL_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_q.fall |-> (!bclk_q && $past(bclk_q))); // R4
  AST_BCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !bclk_q); // R8
endmodule

// File: rtl/acg_ws_gen.sv
module acg_ws_gen #(
  parameter int unsigned CODE_W   = acg_pkg::ACG_WS_W,
  parameter int unsigned BASE     = acg_pkg::ACG_WS_BASE,
  parameter int unsigned MAX_CODE = acg_pkg::ACG_WS_MAX_CODE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              bclk_fall_i,
  output logic              ws_o
);
  localparam int unsigned LEN_W = $clog2(BASE + MAX_CODE);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] last_q, last_d;
  logic             ws_q, ws_d;
  logic [LEN_W-1:0] last_new;

  // Last count index of a level: BASE + min(code, MAX_CODE) - 1.
  function automatic logic [LEN_W-1:0] last_of(input logic [CODE_W-1:0] c);
    int unsigned v;
    v = (int'(c) > int'(MAX_CODE)) ? MAX_CODE : int'(c);
    return LEN_W'(v + BASE - 1);
  endfunction

  always_comb begin
    last_new = last_of(code_i);
    cnt_d    = cnt_q;
    last_d   = last_q;
    ws_d     = ws_q;
    if (!run_i) begin
      cnt_d  = '0;
      last_d = last_new;
      ws_d   = 1'b0;
    end else if (bclk_fall_i) begin
      if (cnt_q == last_q) begin
        cnt_d  = '0;
        last_d = last_new;
        ws_d   = ~ws_q;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= '0;
      ws_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
      ws_q   <= ws_d;
    end
  end

  assign ws_o = ws_q;

  AST_WS_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= last_q)); // R5
  AST_WS_LAST_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> ((last_q >= LEN_W'(BASE - 1)) && (last_q <= LEN_W'(BASE + MAX_CODE - 1)))); // R6
  AST_WS_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !ws_q); // R8
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int unsigned MDIV_W      = acg_pkg::ACG_MDIV_W,
  parameter int unsigned BDIV_W      = acg_pkg::ACG_BDIV_W,
  parameter int unsigned WS_W        = acg_pkg::ACG_WS_W,
  parameter int unsigned WS_BASE     = acg_pkg::ACG_WS_BASE,
  parameter int unsigned WS_MAX_CODE = acg_pkg::ACG_WS_MAX_CODE,
  parameter int unsigned SYNC_STAGES = acg_pkg::ACG_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [MDIV_W-1:0] mclk_code_i,
  input  logic [BDIV_W-1:0] bclk_code_i,
  input  logic [WS_W-1:0]   ws_code_i,
  output logic              mclk_o,
  output logic              bclk_o,
  output logic              ws_o,
  output logic              bclk_rise_o,
  output logic              bclk_fall_o
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;
  logic                   run_q;
  logic                   fall_next;
  acg_pkg::acg_edge_t     bedge;

  // Reset asserts at once and leaves in step with the clock.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) run_q <= 1'b0;
    else            run_q <= en_i;
  end

  acg_mclk_div #(.DIV_W(MDIV_W)) u_mclk (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .run_i  (run_q),
    .code_i (mclk_code_i),
    .mclk_o (mclk_o)
  );

  acg_bclk_div #(.DIV_W(BDIV_W)) u_bclk (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .run_i       (run_q),
    .code_i      (bclk_code_i),
    .bclk_o      (bclk_o),
    .fall_next_o (fall_next),
    .edge_o      (bedge)
  );

  acg_ws_gen #(
    .CODE_W   (WS_W),
    .BASE     (WS_BASE),
    .MAX_CODE (WS_MAX_CODE)
  ) u_ws (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .run_i       (run_q),
    .code_i      (ws_code_i),
    .bclk_fall_i (fall_next),
    .ws_o        (ws_o)
  );

  assign bclk_rise_o = bedge.rise;
  assign bclk_fall_o = bedge.fall;

  AST_WS_ON_BCLK_FALL: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    ($past(run_q) && !$stable(ws_o)) |-> bclk_fall_o); // R7
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !(bclk_rise_o && bclk_fall_o)); // R4
endmodule

// File: tb/audio_clkgen_bench.sv
`timescale 1ns/1ps
module audio_clkgen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [5:0] mcode;
  logic [7:0] bcode;
  logic [4:0] wcode;
  logic       mclk_o, bclk_o, ws_o, bclk_rise_o, bclk_fall_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  audio_clkgen u_audio_clkgen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .mclk_code_i (mcode),
    .bclk_code_i (bcode),
    .ws_code_i   (wcode),
    .mclk_o      (mclk_o),
    .bclk_o      (bclk_o),
    .ws_o        (ws_o),
    .bclk_rise_o (bclk_rise_o),
    .bclk_fall_o (bclk_fall_o)
  );

  function automatic int f_bhalf(input int c); return c + 1; endfunction
  function automatic int f_mhigh(input int c); return c / 2 + 1; endfunction
  function automatic int f_mlow(input int c);  return (c + 1) / 2; endfunction
  function automatic int f_ws(input int c);    return ((c > 16) ? 16 : c) + 16; endfunction

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Allowed phase lengths: pair a is the settled value, pair b the pending one.
  int  eb_a, eb_b, emh_a, emh_b, eml_a, eml_b, ew_a, ew_b;
  bit  mpass, wres;
  int  b_len, m_len, fcnt, wtog, idle_n;
  bit  b_ok, m_ok, bprev, mprev, wprev;

  always @(negedge clk) begin
    if (!rst_n) begin
      idle_n = 0; b_ok = 0; m_ok = 0; fcnt = 0; wtog = 0;
    end else if (!en) begin
      idle_n++; b_ok = 0; m_ok = 0; fcnt = 0; wtog = 0;
      if (idle_n == 3)
        chk("R8 idle outputs", {mclk_o, bclk_o, ws_o, bclk_rise_o, bclk_fall_o} == 5'b0,
            int'({mclk_o, bclk_o, ws_o, bclk_rise_o, bclk_fall_o}), 0);
    end else begin
      idle_n = 0;
      chk("R4 rise strobe", bclk_rise_o == (bclk_o && !bprev), bclk_rise_o, int'(bclk_o && !bprev));
      chk("R4 fall strobe", bclk_fall_o == (!bclk_o && bprev), bclk_fall_o, int'(!bclk_o && bprev));
      if (bclk_o != bprev) begin
        if (b_ok) chk("R3 bit half", (b_len == eb_a) || (b_len == eb_b), b_len, eb_a);
        b_ok = 1; b_len = 1;
      end else b_len++;
      if (!mpass) begin
        if (mclk_o != mprev) begin
          if (m_ok) begin
            if (mprev) chk("R1 master high", (m_len == emh_a) || (m_len == emh_b), m_len, emh_a);
            else       chk("R1 master low",  (m_len == eml_a) || (m_len == eml_b), m_len, eml_a);
          end
          m_ok = 1; m_len = 1;
        end else m_len++;
      end
      if (bclk_fall_o) fcnt++;
      if (ws_o != wprev) begin
        chk("R7 ws on fall", bclk_fall_o, bclk_fall_o, 1);
        chk(wres ? "R6 ws clamp" : "R5 ws half", (fcnt == ew_a) || (fcnt == ew_b), fcnt, ew_a);
        fcnt = 0; wtog++;
      end
    end
    bprev = bclk_o; mprev = mclk_o; wprev = ws_o;
  end

  task automatic set_exp(input int m, input int b, input int w);
    emh_a = f_mhigh(m); emh_b = emh_a;
    eml_a = f_mlow(m);  eml_b = eml_a;
    eb_a  = f_bhalf(b); eb_b  = eb_a;
    ew_a  = f_ws(w);    ew_b  = ew_a;
    mpass = (m == 0);
    wres  = (w > 16);
  endtask

  task automatic run_window(input int m, input int b, input int w, input int ncyc, input bit need_ws);
    @(negedge clk); en = 1'b0;
    repeat (5) @(negedge clk);
    mcode = 6'(m); bcode = 8'(b); wcode = 5'(w);
    set_exp(m, b, w);
    en = 1'b1;
    repeat (ncyc) @(negedge clk);
    if (need_ws) chk(w > 16 ? "R6 ws toggled" : "R5 ws toggled", wtog >= 2, wtog, 2);
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; en = 1'b0; mcode = '0; bcode = '0; wcode = '0;
    set_exp(0, 0, 0);
    repeat (4) @(negedge clk);
    chk("R9 reset outputs", {mclk_o, bclk_o, ws_o, bclk_rise_o, bclk_fall_o} == 5'b0,
        int'({mclk_o, bclk_o, ws_o, bclk_rise_o, bclk_fall_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: default codes; also R2 pass-through
    run_window(0, 0, 0, 200, 1'b1);
    chk("R9 default ws toggles", wtog >= 4, wtog, 4);
    @(posedge clk); #1;
    chk("R2 pass high", mclk_o == 1'b1, mclk_o, 1);
    @(negedge clk); #1;
    chk("R2 pass low", mclk_o == 1'b0, mclk_o, 0);

    run_window(63, 0, 16, 400, 1'b1);      // R1 slowest master, R5 longest legal
    run_window(2, 255, 0, 2600, 1'b0);     // R1 odd ratio, R3 slowest bit clock
    run_window(5, 1, 31, 500, 1'b1);       // R6 top reserved code
    run_window(1, 0, 17, 300, 1'b1);       // R6 lowest reserved code

    for (int i = 0; i < 10; i++) begin
      int m, b, w;
      m = $urandom_range(63, 1);
      b = $urandom_range(5, 0);
      w = $urandom_range(31, 0);
      run_window(m, b, w, 3 * 32 * 2 * (b + 1) + 100, 1'b1);
    end

    // R10: change every code while running
    run_window(4, 2, 3, 400, 1'b1);
    @(negedge clk);
    emh_b = f_mhigh(9); eml_b = f_mlow(9); eb_b = f_bhalf(5); ew_b = f_ws(10);
    mcode = 6'd9; bcode = 8'd5; wcode = 5'd10;
    repeat (600) @(negedge clk);
    set_exp(9, 5, 10);
    wtog = 0;
    repeat (1500) @(negedge clk);
    chk("R10 ws after change", wtog >= 2, wtog, 2);

    @(negedge clk); en = 1'b0;
    repeat (6) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule